// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of a serial port. It watches four active-low modem control lines: carrier detect, ring indicator, data set ready and clear to send. Each line passes through a two-flop synchronizer. The register reports the current level of each line as an active-high status bit. It also keeps a sticky change flag for each line that records a transition since the flag was last cleared. The ring-indicator flag is the exception: it records only the trailing edge, where the pin falls from high to low.

The register also holds a read/write flow-control mode bit, which drives an output straight to the flow-control logic. Software reaches the register through a single-cycle read strobe and write strobe with 32-bit data. Read data is combinational from the current register contents. A compile-time parameter selects how the change flags are cleared: either every flag clears on any read, or each flag clears when a one is written to its position.

Top module: `uart_modem_status`

## Requirements
- R1: Bits 31:9 of the read data are always 0, and writes to those bits change nothing.
- R2: Bit 8 is the flow-control mode bit (1 = enabled). A write loads it from write-data bit 8, and the `flow_en` output equals it from the cycle after the write.
- R3: Bits 7, 6, 5 and 4 report carrier detect, ring indicator, data set ready and clear to send. Each reads 1 when its pin is low and 0 when its pin is high. A pin change shows up two clock edges after it arrives, and writes to these bits are ignored.
- R4: Bit 3 becomes 1 after the synchronized carrier-detect pin changes level in either direction, and it stays 1 until cleared.
- R5: Bit 2 becomes 1 only when the synchronized ring-indicator pin goes from high to low. A low-to-high change leaves it unchanged.
- R6: Bit 1 (data set ready) and bit 0 (clear to send) each become 1 after their synchronized pin changes level in either direction, and they stay 1 until cleared.
- R7: With `CLEAR_ON_READ` = 1 (the default), a read strobe clears bits 3:0 together at the end of that cycle. The read data in the strobe cycle still shows the flags as they were before the clear. Writes do not affect bits 3:0.
- R8: With `CLEAR_ON_READ` = 0, reads leave bits 3:0 unchanged. A write clears each bit of 3:0 whose write-data bit is 1 and leaves the bits whose write-data bit is 0.
- R9: When a line change and a clearing read or write fall in the same cycle, the change flag ends up 1.
- R10: After reset the flow-control bit and bits 3:0 are 0. Pins that are held low through reset and afterwards raise no change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdm_carrier_n | input | 1 | Carrier detect line, active low, asynchronous |
| mdm_ring_n | input | 1 | Ring indicator line, active low, asynchronous |
| mdm_ready_n | input | 1 | Data set ready line, active low, asynchronous |
| mdm_clear_n | input | 1 | Clear to send line, active low, asynchronous |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register contents, combinational |
| flow_en | output | 1 | Flow-control mode enable |

## Verification
A vector table steps the four lines through single-line falls and rises, two-line changes and an all-lines swing in both directions. These patterns separate the either-edge flags from the trailing-edge-only ring flag, and they show that each flag is tied to its own line and bit. Directed cases then cover a clearing read that lands on the same edge as a new change, a write of all ones in clear-on-read mode, and reads compared with selective one-writes in the write-one-to-clear instance. A final case holds the lines low through reset, which separates a real transition from the synchronizer settling after reset.

// File: rtl/uart_modem_status_pkg.sv
package uart_modem_status_pkg;

    // Line order inside every 4-bit line vector; the delta field mirrors it.
    localparam int unsigned LINE_COUNT  = 4;
    localparam int unsigned IDX_CARRIER = 3;
    localparam int unsigned IDX_RING    = 2;
    localparam int unsigned IDX_READY   = 1;
    localparam int unsigned IDX_CLEAR   = 0;

    // Register field positions.
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned DELTA_LSB   = 0;
    localparam int unsigned LEVEL_LSB   = 4;
    localparam int unsigned FLOW_BIT    = 8;

    // Lines whose change flag records only a high-to-low pin transition.
    localparam logic [LINE_COUNT-1:0] FALL_ONLY_MASK = 4'b0100;

    typedef logic [LINE_COUNT-1:0] line_vec_t;

endpackage

// File: rtl/msr_sync.sv
module msr_sync
    import uart_modem_status_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t pins_async,
    output line_vec_t pins_sync
);

    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            if (STAGES > 1) begin
                chain_d = {chain_q[STAGES-2:0], pins_async[g]};
            end else begin
                chain_d = pins_async[g];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign pins_sync[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/msr_edge.sv
module msr_edge
    import uart_modem_status_pkg::*;
#(
    parameter line_vec_t FALL_ONLY = FALL_ONLY_MASK
) (
    input  line_vec_t now_lvl,
    input  line_vec_t prev_lvl,
    input  logic      armed,
    output line_vec_t set_vec
);

    for (genvar g = 0; g < LINE_COUNT; g++) begin : g_det
        if (FALL_ONLY[g]) begin : g_fall
            assign set_vec[g] = armed & prev_lvl[g] & ~now_lvl[g];
        end else begin : g_any
            assign set_vec[g] = armed & (prev_lvl[g] ^ now_lvl[g]);
        end
    end

endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import uart_modem_status_pkg::*;
#(
    parameter bit          CLEAR_ON_READ = 1'b1,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mdm_carrier_n,
    input  logic        mdm_ring_n,
    input  logic        mdm_ready_n,
    input  logic        mdm_clear_n,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        flow_en
);

    localparam int unsigned WARM_MAX = SYNC_STAGES + 1;
    localparam int unsigned WARM_W   = $clog2(WARM_MAX + 1);

    typedef struct packed {
        logic              flow;
        line_vec_t         delta;
        line_vec_t         hist;
        logic [WARM_W-1:0] warm;
    } msr_state_t;

    msr_state_t s_d;
    msr_state_t s_q;

    line_vec_t pins_raw;
    line_vec_t pins_sync;
    line_vec_t set_vec;
    line_vec_t clr_vec;
    logic      armed;
    logic      unused_wdata;

    assign pins_raw = {mdm_carrier_n, mdm_ring_n, mdm_ready_n, mdm_clear_n};
    assign unused_wdata = ^wdata;

    msr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_raw),
        .pins_sync  (pins_sync)
    );

    // Detection stays off until the history has been loaded with settled levels.
    assign armed = (s_q.warm == WARM_W'(WARM_MAX));

    msr_edge #(.FALL_ONLY(FALL_ONLY_MASK)) edge_i (
        .now_lvl  (pins_sync),
        .prev_lvl (s_q.hist),
        .armed    (armed),
        .set_vec  (set_vec)
    );

    if (CLEAR_ON_READ) begin : g_clr_read
        assign clr_vec = {LINE_COUNT{rd_en}};
    end else begin : g_clr_w1c
        assign clr_vec = wr_en ? wdata[DELTA_LSB +: LINE_COUNT] : '0;
    end

    always_comb begin
        s_d      = s_q;
        s_d.hist = pins_sync;
        if (s_q.warm != WARM_W'(WARM_MAX)) begin
            s_d.warm = s_q.warm + 1'b1;
        end
        // A new change outranks a clear in the same cycle.
        s_d.delta = set_vec | (s_q.delta & ~clr_vec);
        if (wr_en) begin
            s_d.flow = wdata[FLOW_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flow  <= 1'b0;
            s_q.delta <= '0;
            s_q.hist  <= '1;
            s_q.warm  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        rdata[FLOW_BIT] = s_q.flow;
        rdata[LEVEL_LSB +: LINE_COUNT] = ~pins_sync;
        rdata[DELTA_LSB +: LINE_COUNT] = s_q.delta;
    end

    assign flow_en = s_q.flow;

endmodule

// File: rtl/uart_modem_status_chk.sv
module uart_modem_status_chk #(
    parameter bit CLEAR_ON_READ = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        wr_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        flow_en
);

    logic [1:0] age_q;
    logic       old_enough;
    logic       clr3;
    logic       unused_chk;

    assign unused_chk = ^wdata;
    assign old_enough = (age_q == 2'd3);
    assign clr3 = CLEAR_ON_READ ? rd_en : (wr_en & wdata[3]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:9] == 23'd0);

    a_r2_flow_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flow_en == $past(wdata[8])) && (rdata[8] == flow_en));

    a_r7_r8_carrier_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[3] && !clr3) |=> rdata[3]);

    // R4: a new carrier flag follows a level change seen one edge earlier.
    a_r4_carrier_cause: assert property (@(posedge clk) disable iff (!rst_n || !old_enough)
        $rose(rdata[3]) |-> ($past(rdata[7]) != $past(rdata[7], 2)));

    // R5: a new ring flag follows the reported level going from 0 to 1 (pin falling).
    a_r5_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n || !old_enough)
        $rose(rdata[2]) |-> ($past(rdata[6]) && !$past(rdata[6], 2)));

endmodule

bind uart_modem_status uart_modem_status_chk #(.CLEAR_ON_READ(CLEAR_ON_READ)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .flow_en (flow_en)
);

// File: tb/uart_modem_status_tb_top.sv
module uart_modem_status_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {pins carrier,ring,ready,clear (active low), expected rdata[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {4'b1111, 8'h00},
        {4'b0111, 8'h88},
        {4'b1011, 8'h4C},
        {4'b1111, 8'h00},
        {4'b1100, 8'h33},
        {4'b0000, 8'hFC},
        {4'b1111, 8'h0B},
        {4'b1110, 8'h11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins = 4'b1111;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        w_rd = 1'b0, w_wr = 1'b0;
    logic [31:0] w_wdata = '0;
    logic [31:0] rdata, w_rdata;
    logic        flow_en, w_flow;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_status dut_i (
        .clk(clk), .rst_n(rst_n),
        .mdm_carrier_n(pins[3]), .mdm_ring_n(pins[2]),
        .mdm_ready_n(pins[1]), .mdm_clear_n(pins[0]),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .flow_en(flow_en)
    );

    uart_modem_status #(.CLEAR_ON_READ(1'b0)) dut_w1c_i (
        .clk(clk), .rst_n(rst_n),
        .mdm_carrier_n(pins[3]), .mdm_ring_n(pins[2]),
        .mdm_ready_n(pins[1]), .mdm_clear_n(pins[0]),
        .rd_en(w_rd), .wr_en(w_wr), .wdata(w_wdata),
        .rdata(w_rdata), .flow_en(w_flow)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(4);
        // R10 / R2: reset state
        check("R10 reset rdata", rdata, 32'h0);
        check("R2 reset flow_en", {31'd0, flow_en}, 32'h0);

        // R3 R4 R5 R6 R7: vector walk, read in each step clears flags
        for (int i = 0; i < NVEC; i++) begin
            pins = VEC[i][11:8];
            tick(4);
            rd_en = 1'b1;
            check($sformatf("R3 R4 R5 R6 vec%0d", i), rdata, {24'd0, VEC[i][7:0]});
            tick(1);
            rd_en = 1'b0;
            check($sformatf("R7 cleared vec%0d", i), rdata, {24'd0, VEC[i][7:4], 4'h0});
        end

        // R9: clearing read on the same edge as a new ready change
        pins = 4'b1100;
        tick(2);
        rd_en = 1'b1;
        check("R9 before set", {31'd0, rdata[1]}, 32'd0);
        tick(1);
        rd_en = 1'b0;
        check("R9 set wins", {31'd0, rdata[1]}, 32'd1);

        // R1 R2 R3 R7: all-ones write
        wr_en = 1'b1; wdata = 32'hFFFF_FFFF;
        tick(1);
        wr_en = 1'b0; wdata = '0;
        check("R1 R2 R3 R7 write ones", rdata, 32'h0000_0132);
        check("R2 flow_en on", {31'd0, flow_en}, 32'd1);
        wr_en = 1'b1; wdata = 32'h0;
        tick(1);
        wr_en = 1'b0;
        check("R2 flow_en off", {31'd0, flow_en}, 32'd0);
        check("R7 write leaves flag", {28'd0, rdata[3:0]}, 32'h2);

        // R8: write-one-to-clear instance
        w_wr = 1'b1; w_wdata = 32'hF;
        tick(1);
        w_wr = 1'b0; w_wdata = '0;
        check("R8 all cleared", {28'd0, w_rdata[3:0]}, 32'h0);
        pins = 4'b0100;
        tick(4);
        check("R8 R4 carrier set", {28'd0, w_rdata[3:0]}, 32'h8);
        w_rd = 1'b1;
        tick(1);
        w_rd = 1'b0;
        check("R8 read no clear", {28'd0, w_rdata[3:0]}, 32'h8);
        w_wr = 1'b1; w_wdata = 32'h7;
        tick(1);
        w_wr = 1'b0;
        check("R8 zero keeps", {28'd0, w_rdata[3:0]}, 32'h8);
        w_wr = 1'b1; w_wdata = 32'h8;
        tick(1);
        w_wr = 1'b0; w_wdata = '0;
        check("R8 one clears", {28'd0, w_rdata[3:0]}, 32'h0);

        // R5: ring rising pin sets nothing
        pins = 4'b0000;
        tick(4);
        w_wr = 1'b1; w_wdata = 32'hF;
        tick(1);
        w_wr = 1'b0; w_wdata = '0;
        pins = 4'b0100;
        tick(4);
        check("R5 ring rise ignored", w_rdata, 32'h0000_00B0);

        // R10: pins low through reset
        pins = 4'b0000;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(6);
        check("R10 no false delta", rdata, 32'h0000_00F0);
        check("R10 no false delta w1c", w_rdata, 32'h0000_00F0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule